// File: doc/BRIEF.md
# Adaptive switching threshold calibrator

This block sets the switching threshold of a magnetic position sensor. The threshold is a 10-bit offset code. The block reads a stream of digitised field samples, expressed in offset-code LSBs. It finds the peaks and valleys of that stream and moves the threshold towards a weighted point between the last maximum and minimum. The output comparator stage reports each output switching event. It also reports the current direction of the magnetic edge. The block uses these two inputs to pace its corrections and to gate their sign.

Operation has three modes. Initial mode holds a start threshold. That value is either a programmed code or the result of an external search. In precalibrated mode, large corrections are allowed, each limited in size and gated by edge direction. In calibrated mode, one small correction per window of switching events passes through a direction filter. Two plausibility watchdogs send the block back to initial mode and emit a one-cycle soft-reset request. One fires when switching stops for too many slow ticks. The other fires when too many extremes arrive without a switching event.

Top module: `thr_calibrator`

## Requirements
- R1: After reset, and after any soft reset, the mode output is 0 (initial). While in initial mode the threshold follows `prog_code` when `is_prog` is high. When `is_prog` is low, the threshold loads `search_code` on a `search_valid` strobe. Detected extremes never change the threshold in initial mode.
- R2: The target is floor((max·w + min·(256−w))/256). Here w = 86 + 16·`prog_k` when programmed, and w = 128 when unprogrammed. So `prog_k`=3 gives 134/256 and `prog_k`=7 gives 198/256.
- R3: In precalibrated mode, one correction moves the threshold by at most STEP_LSB (default 118) codes.
- R4: A pending precalibrated correction that raises the threshold is applied only while `mag_rise` is 1. One that lowers it is applied only while `mag_rise` is 0. Until then it waits.
- R5: A maximum is reported once the signal has fallen more than HYS (default 4) codes below its running peak. A minimum is reported once the signal has risen more than HYS codes above its running valley. In precalibrated mode, before the 16th switching event, every extreme after which both a maximum and a minimum are known schedules a correction from the latest pair.
- R6: From the 16th to the 32nd switching event, extremes schedule nothing. At the 32nd event, one correction is scheduled from the highest maximum and lowest minimum seen since the 16th event, and the mode becomes 2 (calibrated).
- R7: In calibrated mode, each window of 32 switching events yields one adjustment, computed from that window's absolute maximum and minimum. The threshold moves on the fourth consecutive adjustment in the same direction, and on every further one in that direction. A change of direction restarts the count.
- R8: A calibrated adjustment counts only if its magnitude exceeds ACT_LSB (default 2). A smaller one clears the run. Each calibrated update moves the threshold by exactly 1 code.
- R9: If four extremes are detected with no switching event between them, `soft_rst_req` pulses for one cycle and the mode returns to 0.
- R10: If WD_TICKS (default 12) `slow_tick` pulses arrive with no switching event, `soft_rst_req` pulses and the mode returns to 0.
- R11: Mode codes are 0 initial, 1 precalibrated and 2 calibrated. Initial never goes straight to calibrated, and the first switching event moves initial to precalibrated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 10 | Digitised field sample in offset-code LSBs |
| sw_evt | input | 1 | Output switching event strobe |
| mag_rise | input | 1 | 1 while the magnetic edge is rising |
| slow_tick | input | 1 | Slow time-base pulse for the inactivity watchdog |
| is_prog | input | 1 | Threshold has been programmed |
| prog_k | input | 3 | Programmed weight selector |
| prog_code | input | 10 | Programmed start threshold |
| search_valid | input | 1 | External search result strobe |
| search_code | input | 10 | External search result |
| thr_code | output | 10 | Current threshold code |
| mode | output | 2 | Current mode |
| soft_rst_req | output | 1 | One-cycle request to return to initial mode |

## Verification
The hardest state to reach is the calibrated direction filter. Its run count can only be seen after the block has passed 32 switching events. It also needs windows whose extremes put the target above, below or barely beside the threshold. The stimulus makes one rise and one fall per window, with the peak height chosen arithmetically, and then issues 32 switching events. Runs of up, down and sub-activation windows then show on the threshold whether the count advanced, restarted or cleared. The phase-B window is checked the same way: a peak from phase A that would skew the result is placed just before the 16th event.

// File: rtl/thr_cal_pkg.sv
package thr_cal_pkg;
  typedef enum logic [1:0] {
    M_INIT = 2'd0,
    M_PRE  = 2'd1,
    M_CAL  = 2'd2
  } mode_t;

  localparam int W_BASE = 86;   // 0.3359 in 1/256 units
  localparam int W_STEP = 16;   // 0.0625 per k step
  localparam int W_HALF = 128;  // 0.5 for an unprogrammed part

  function automatic logic [8:0] k_weight(input logic prog, input logic [2:0] k);
    if (prog) return 9'(W_BASE + W_STEP * int'(k));
    return 9'(W_HALF);
  endfunction
endpackage

// File: rtl/thr_extreme_track.sv
module thr_extreme_track #(
  parameter int DW  = 10,
  parameter int HYS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_code,
  output logic          max_evt,
  output logic          min_evt,
  output logic [DW-1:0] ext_val
);
  logic          rising;
  logic [DW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rising  <= 1'b1;
      run     <= '0;
      max_evt <= 1'b0;
      min_evt <= 1'b0;
      ext_val <= '0;
    end else begin
      max_evt <= 1'b0;
      min_evt <= 1'b0;
      if (smp_valid) begin
        if (rising) begin
          if (smp_code > run) run <= smp_code;
          else if (run - smp_code > DW'(HYS)) begin
            max_evt <= 1'b1;
            ext_val <= run;
            rising  <= 1'b0;
            run     <= smp_code;
          end
        end else begin
          if (smp_code < run) run <= smp_code;
          else if (smp_code - run > DW'(HYS)) begin
            min_evt <= 1'b1;
            ext_val <= run;
            rising  <= 1'b1;
            run     <= smp_code;
          end
        end
      end
    end
  end
endmodule

// File: rtl/thr_weight.sv
module thr_weight #(
  parameter int DW = 10
) (
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  input  logic [8:0]    w,
  output logic [DW-1:0] tgt
);
  localparam int AW = DW + 10;
  logic [AW-1:0] acc;
  logic [AW-1:0] q;

  always_comb begin
    acc = AW'(hi) * AW'(w) + AW'(lo) * AW'(9'd256 - w);
    q   = acc >> 8;
    tgt = (q > AW'((1 << DW) - 1)) ? '1 : q[DW-1:0];
  end
endmodule

// File: rtl/thr_dir_filter.sv
module thr_dir_filter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic evt,
  input  logic big,
  input  logic up,
  output logic fire
);
  localparam int CW = $clog2(RUN_LEN + 1);
  logic [CW-1:0] cnt;
  logic          last_up;
  logic          same;

  assign same = (cnt != '0) && (last_up == up);
  assign fire = evt && big && same && (cnt >= CW'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      last_up <= 1'b0;
    end else if (evt) begin
      if (!big) cnt <= '0;
      else if (same) cnt <= (cnt == CW'(RUN_LEN)) ? cnt : cnt + 1'b1;
      else begin
        cnt     <= CW'(1);
        last_up <= up;
      end
    end
  end
endmodule

// File: rtl/thr_watchdog.sv
module thr_watchdog #(
  parameter int WD_TICKS  = 12,
  parameter int EXT_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_evt,
  input  logic slow_tick,
  input  logic ext_evt,
  output logic fire
);
  localparam int TW = $clog2(WD_TICKS + 1);
  localparam int XW = $clog2(EXT_LIMIT + 1);
  logic [TW-1:0] tcnt;
  logic [XW-1:0] ecnt;

  assign fire = !sw_evt &&
                ((slow_tick && tcnt == TW'(WD_TICKS - 1)) ||
                 (ext_evt && ecnt == XW'(EXT_LIMIT - 1)));

  always_ff @(posedge clk) begin
    if (rst || sw_evt || fire) begin
      tcnt <= '0;
      ecnt <= '0;
    end else begin
      if (slow_tick) tcnt <= tcnt + 1'b1;
      if (ext_evt)   ecnt <= ecnt + 1'b1;
    end
  end
endmodule

// File: rtl/thr_calibrator.sv
module thr_calibrator
  import thr_cal_pkg::*;
#(
  parameter int DW         = 10,
  parameter int HYS        = 4,
  parameter int STEP_LSB   = 118,
  parameter int ACT_LSB    = 2,
  parameter int PHASE_EVTS = 16,
  parameter int RUN_LEN    = 4,
  parameter int EXT_LIMIT  = 4,
  parameter int WD_TICKS   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_code,
  input  logic          sw_evt,
  input  logic          mag_rise,
  input  logic          slow_tick,
  input  logic          is_prog,
  input  logic [2:0]    prog_k,
  input  logic [DW-1:0] prog_code,
  input  logic          search_valid,
  input  logic [DW-1:0] search_code,
  output logic [DW-1:0] thr_code,
  output logic [1:0]    mode,
  output logic          soft_rst_req
);
  localparam int WIN_EVTS = 2 * PHASE_EVTS;
  localparam int EW       = $clog2(WIN_EVTS);
  localparam int SW       = DW + 2;
  localparam logic signed [SW-1:0] STEP_S = SW'(STEP_LSB);
  localparam logic signed [SW-1:0] ACT_S  = SW'(ACT_LSB);
  localparam logic signed [SW:0]   MAXV   = (SW+1)'((1 << DW) - 1);

  mode_t                 mode_q;
  logic [DW-1:0]         thr_q, lat_max, lat_min, win_max, win_min;
  logic                  lat_hv, lat_lv, win_hv, win_lv;
  logic [EW-1:0]         ev_cnt;
  logic                  pend_v;
  logic signed [SW-1:0]  pend_d;

  logic                  max_evt, min_evt, wd_fire, f_fire;
  logic [DW-1:0]         ext_val, nxt_max, nxt_min, tgt_pair, tgt_win;
  logic [8:0]            w;
  logic signed [SW-1:0]  d_pair, d_win;
  logic signed [SW:0]    sum;
  logic                  phase_a, pair_upd, win_last, win_ok, pre_b_upd, cal_end;
  logic                  cal_big, pend_apply, win_restart;

  function automatic logic signed [SW-1:0] lim(input logic signed [SW-1:0] d);
    if (d > STEP_S)  return STEP_S;
    if (d < -STEP_S) return -STEP_S;
    return d;
  endfunction

  thr_extreme_track #(.DW(DW), .HYS(HYS)) u_track (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .max_evt(max_evt), .min_evt(min_evt), .ext_val(ext_val));

  assign w       = k_weight(is_prog, prog_k);
  assign nxt_max = max_evt ? ext_val : lat_max;
  assign nxt_min = min_evt ? ext_val : lat_min;

  thr_weight #(.DW(DW)) u_w_pair (.hi(nxt_max), .lo(nxt_min), .w(w), .tgt(tgt_pair));
  thr_weight #(.DW(DW)) u_w_win  (.hi(win_max), .lo(win_min), .w(w), .tgt(tgt_win));

  assign d_pair = $signed({2'b00, tgt_pair}) - $signed({2'b00, thr_q});
  assign d_win  = $signed({2'b00, tgt_win})  - $signed({2'b00, thr_q});

  assign phase_a     = (mode_q == M_PRE) && (ev_cnt < EW'(PHASE_EVTS));
  assign pair_upd    = phase_a && (max_evt || min_evt) &&
                       (max_evt || lat_hv) && (min_evt || lat_lv);
  assign win_last    = sw_evt && (mode_q != M_INIT) && (ev_cnt == EW'(WIN_EVTS - 1));
  assign win_restart = win_last ||
                       (sw_evt && mode_q == M_PRE && ev_cnt == EW'(PHASE_EVTS - 1));
  assign win_ok      = win_hv && win_lv;
  assign pre_b_upd   = win_last && (mode_q == M_PRE) && win_ok;
  assign cal_end     = win_last && (mode_q == M_CAL);
  assign cal_big     = win_ok && ((d_win > ACT_S) || (d_win < -ACT_S));
  assign pend_apply  = pend_v && ((pend_d > 0 && mag_rise) || (pend_d < 0 && !mag_rise));
  assign sum         = $signed({3'b000, thr_q}) + $signed({pend_d[SW-1], pend_d});

  thr_dir_filter #(.RUN_LEN(RUN_LEN)) u_filt (
    .clk(clk), .rst(rst), .clr(wd_fire), .evt(cal_end), .big(cal_big),
    .up(d_win > 0), .fire(f_fire));

  thr_watchdog #(.WD_TICKS(WD_TICKS), .EXT_LIMIT(EXT_LIMIT)) u_wd (
    .clk(clk), .rst(rst), .sw_evt(sw_evt), .slow_tick(slow_tick),
    .ext_evt(max_evt || min_evt), .fire(wd_fire));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_INIT;  thr_q <= '0;  ev_cnt <= '0;
      lat_max <= '0; lat_min <= '0; lat_hv <= 1'b0; lat_lv <= 1'b0;
      win_max <= '0; win_min <= '0; win_hv <= 1'b0; win_lv <= 1'b0;
      pend_v <= 1'b0; pend_d <= '0; soft_rst_req <= 1'b0;
    end else begin
      soft_rst_req <= wd_fire;
      if (wd_fire) begin
        mode_q <= M_INIT; ev_cnt <= '0;
        lat_hv <= 1'b0; lat_lv <= 1'b0; win_hv <= 1'b0; win_lv <= 1'b0;
        pend_v <= 1'b0;
      end else begin
        // latest extremes
        if (max_evt) begin lat_max <= ext_val; lat_hv <= 1'b1; end
        if (min_evt) begin lat_min <= ext_val; lat_lv <= 1'b1; end
        // window extremes
        if (win_restart) begin
          win_hv <= 1'b0; win_lv <= 1'b0;
        end else begin
          if (max_evt && (!win_hv || ext_val > win_max)) begin win_max <= ext_val; win_hv <= 1'b1; end
          if (min_evt && (!win_lv || ext_val < win_min)) begin win_min <= ext_val; win_lv <= 1'b1; end
        end
        // mode schedule
        if (sw_evt) begin
          case (mode_q)
            M_INIT: begin mode_q <= M_PRE; ev_cnt <= EW'(1); end
            M_PRE:  begin
              if (win_last) begin mode_q <= M_CAL; ev_cnt <= '0; end
              else ev_cnt <= ev_cnt + 1'b1;
            end
            default: ev_cnt <= win_last ? '0 : ev_cnt + 1'b1;
          endcase
        end
        // threshold
        if (mode_q == M_INIT) begin
          if (is_prog) thr_q <= prog_code;
          else if (search_valid) thr_q <= search_code;
        end else if (f_fire) begin
          if (d_win > 0) begin
            if (thr_q != '1) thr_q <= thr_q + 1'b1;
          end else if (thr_q != '0) thr_q <= thr_q - 1'b1;
        end else if (pend_apply) begin
          if (sum < 0) thr_q <= '0;
          else if (sum > MAXV) thr_q <= '1;
          else thr_q <= sum[DW-1:0];
        end
        // pending correction
        if (pair_upd) begin
          pend_v <= 1'b1; pend_d <= lim(d_pair);
        end else if (pre_b_upd) begin
          pend_v <= 1'b1; pend_d <= lim(d_win);
        end else if ((pend_apply && !f_fire) || (pend_v && pend_d == 0)) begin
          pend_v <= 1'b0;
        end
      end
    end
  end

  assign thr_code = thr_q;
  assign mode     = mode_q;
endmodule

// File: rtl/thr_calibrator_chk.sv
module thr_calibrator_chk #(
  parameter int DW       = 10,
  parameter int STEP_LSB = 118
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic [DW-1:0] thr_code,
  input logic          soft_rst_req,
  input logic          is_prog,
  input logic [DW-1:0] prog_code,
  input logic          mag_rise
);
  p_prog_load_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && is_prog) |=> (soft_rst_req || thr_code == $past(prog_code)));

  p_step_limit_r3: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0) |=> ((int'(thr_code) - int'($past(thr_code)) <= STEP_LSB) &&
                        (int'($past(thr_code)) - int'(thr_code) <= STEP_LSB)));

  p_no_drop_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && mag_rise) |=> (thr_code >= $past(thr_code)));

  p_no_lift_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && !mag_rise) |=> (thr_code <= $past(thr_code)));

  p_soft_rst_init_r9: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |-> (mode == 2'd0));

  p_no_skip_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> (mode != 2'd2));

  p_legal_mode_r11: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3);
endmodule

bind thr_calibrator thr_calibrator_chk #(.DW(DW), .STEP_LSB(STEP_LSB)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .thr_code(thr_code),
  .soft_rst_req(soft_rst_req), .is_prog(is_prog), .prog_code(prog_code),
  .mag_rise(mag_rise));

// File: tb/tb_thr_calibrator.sv
module tb_thr_calibrator;
  localparam int CLK_P = 10;
  localparam int HYS   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_code = '0;
  logic       sw_evt = 1'b0;
  logic       mag_rise = 1'b0;
  logic       slow_tick = 1'b0;
  logic       is_prog = 1'b1;
  logic [2:0] prog_k = 3'd3;
  logic [9:0] prog_code = 10'd300;
  logic       search_valid = 1'b0;
  logic [9:0] search_code = '0;
  logic [9:0] thr_code;
  logic [1:0] mode;
  logic       soft_rst_req;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  thr_calibrator dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .sw_evt(sw_evt), .mag_rise(mag_rise), .slow_tick(slow_tick),
    .is_prog(is_prog), .prog_k(prog_k), .prog_code(prog_code),
    .search_valid(search_valid), .search_code(search_code),
    .thr_code(thr_code), .mode(mode), .soft_rst_req(soft_rst_req));

  always @(posedge clk) if (!rst && soft_rst_req) pulses++;

  function automatic int exp_tgt(input int hi, input int lo, input int w);
    return (hi * w + lo * (256 - w)) / 256;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; idle(3); rst = 1'b0; idle(3);
  endtask

  task automatic sample(input int v);
    @(negedge clk); smp_valid = 1'b1; smp_code = 10'(v);
    @(negedge clk); smp_valid = 1'b0;
    idle(3);
  endtask

  task automatic mx(input int v); sample(v); sample(v - HYS - 6); endtask
  task automatic mn(input int v); sample(v); sample(v + HYS + 6); endtask

  task automatic sw_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sw_evt = 1'b1;
      @(negedge clk); sw_evt = 1'b0;
      idle(2);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
    idle(3);
  endtask

  task automatic cal_win(input int hi);
    mn(50); mx(hi); sw_n(32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog timeout act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    do_reset();
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset req", int'(soft_rst_req), 0);
    chk("R1 programmed load", int'(thr_code), 300);
    mx(600);
    chk("R1 no correction in initial", int'(thr_code), 300);
    sw_n(1);
    chk("R11 first switch to precal", int'(mode), 1);
    mn(200);
    chk("R4 raise held while falling edge", int'(thr_code), 300);
    mag_rise = 1'b1; idle(3);
    chk("R2 R5 pair target k=3", int'(thr_code), exp_tgt(600, 200, 134));
    sw_n(1); mx(1000);
    chk("R3 step clamp", int'(thr_code), 409 + 118);
    sw_n(1); mn(100);
    chk("R5 unclamped pair", int'(thr_code), exp_tgt(1000, 100, 134));
    sw_n(1); mx(150);
    chk("R4 lower held while rising edge", int'(thr_code), 571);
    mag_rise = 1'b0; idle(3);
    chk("R3 R4 negative clamp", int'(thr_code), 571 - 118);
    sw_n(12);                      // 16 switching events so far
    mn(50); sw_n(1); mx(700); sw_n(1); mn(80); sw_n(1); mx(650);
    chk("R6 no per-pair update in phase B", int'(thr_code), 453);
    chk("R6 still precal", int'(mode), 1);
    sw_n(13);                      // 32nd event
    chk("R6 window correction", int'(thr_code), exp_tgt(700, 50, 134));
    chk("R6 calibrated mode", int'(mode), 2);
    for (int i = 0; i < 3; i++) cal_win(710);
    chk("R7 three same-direction windows hold", int'(thr_code), 390);
    cal_win(710);
    chk("R7 fourth window moves", int'(thr_code), 391);
    cal_win(710);
    chk("R8 one LSB per update", int'(thr_code), 392);
    cal_win(650);
    chk("R7 reversal holds", int'(thr_code), 392);
    cal_win(710); cal_win(710);
    chk("R7 restarted run holds", int'(thr_code), 392);
    cal_win(708);
    cal_win(710); cal_win(710);
    chk("R8 activation-level window clears run", int'(thr_code), 392);
    // extreme watchdog
    p0 = pulses;
    mn(100); mx(600); mn(100); mx(600);
    chk("R9 extreme watchdog pulse", pulses - p0, 1);
    chk("R9 back to initial", int'(mode), 0);
    chk("R1 reload after soft reset", int'(thr_code), 300);
    sw_n(1);
    mn(100); mx(600); mn(100); sw_n(1); mx(600);
    chk("R9 three extremes tolerated", pulses - p0, 1);
    chk("R9 mode kept", int'(mode), 1);
    // tick watchdog
    sw_n(1);
    tick_n(11);
    chk("R10 eleven ticks tolerated", pulses - p0, 1);
    sw_n(1); tick_n(11);
    chk("R10 switching restarts count", pulses - p0, 1);
    tick_n(1);
    chk("R10 tick watchdog pulse", pulses - p0, 2);
    chk("R10 back to initial", int'(mode), 0);
    // weight sweep over every k
    for (int k = 0; k < 8; k++) begin
      int t;
      prog_k = 3'(k); prog_code = 10'd420; is_prog = 1'b1;
      t = exp_tgt(600, 200, 86 + 16 * k);
      mag_rise = (t > 420);
      do_reset();
      chk("R1 sweep load", int'(thr_code), 420);
      sw_n(1); mx(600); mn(200);
      chk($sformatf("R2 weight k=%0d", k), int'(thr_code), t);
    end
    // unprogrammed
    is_prog = 1'b0; mag_rise = 1'b0;
    do_reset();
    @(negedge clk); search_code = 10'd512; search_valid = 1'b1;
    @(negedge clk); search_valid = 1'b0; idle(2);
    chk("R1 search load", int'(thr_code), 512);
    sw_n(1); mx(600); mn(200);
    chk("R2 unprogrammed half weight", int'(thr_code), exp_tgt(600, 200, 128));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule